// File: doc/BRIEF.md
# DMA Interrupt Event Collector

This block gathers the per-channel event pulses of a multi-channel DMA engine into four event classes: transfer done, source-side error, destination-side error and configuration error. Each class has one latched raw bit per channel. A pulse sets the bit, and it stays set until software clears it. A pending view of each class ANDs the raw bits with the per-channel interrupt-enable lines. The single interrupt output is the OR of everything pending.

A small word-wide register port serves both software and the arbiter. Software reads the pending and raw views and clears raw bits by writing ones. It also reads a live channel-activity word and holds two configuration words that feed the arbiter: group priority and arbitration mode. Reads are combinational from the current register state. Writes take effect at the clock edge. The per-channel engines that produce the pulses, the enables and the activity lines are outside this block.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every raw bit is zero, the group-priority and arbitration words are zero, and `irq` is low.
- R2: A one-cycle pulse on channel n of a class sets bit n of that class's raw word. The raw words sit at 0x810 (done), 0x814 (source error), 0x818 (destination error) and 0x81C (configuration error). The bit reads as one from the cycle after the pulse and stays set with no further pulses.
- R3: The pending words at 0x800, 0x804, 0x808 and 0x80C (same class order) read as the class's raw word ANDed with `ch_irq_en`. Bit n always belongs to channel n.
- R4: A write to a raw word clears every bit that is one in the written data and leaves all other bits unchanged.
- R5: When an event pulse for a bit arrives in the same cycle as a clear write covering that bit, the bit stays set.
- R6: `irq` is high exactly when at least one bit of the four pending words is one.
- R7: The word at 0x820 reads the live `ch_active` lines, bit n for channel n. Writes to it are ignored.
- R8: The word at 0x824 is a full-width read/write group-priority register driven on `grp_prio`. The word at 0x828 holds an ARB_W-bit arbitration mode driven on `arb_sel`, and its upper bits read as zero. A mode of zero means all channels have equal priority.
- R9: Writes to the pending words are ignored. Any address outside 0x800–0x828 reads as zero, and writes to it change nothing.
- R10: Writing all ones to the four raw words clears every event and drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_done | input | NUM_CH | Transfer-done pulses, one per channel |
| evt_src_err | input | NUM_CH | Source-error pulses |
| evt_dst_err | input | NUM_CH | Destination-error pulses |
| evt_cfg_err | input | NUM_CH | Configuration-error pulses |
| ch_irq_en | input | NUM_CH | Per-channel interrupt enables |
| ch_active | input | NUM_CH | Live channel activity |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data (combinational) |
| grp_prio | output | REG_W | Group-priority word to the arbiter |
| arb_sel | output | ARB_W | Arbitration mode to the arbiter |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take three things for granted about the inputs. Event lines carry single-cycle pulses. Every rising raw bit traces back to such a pulse. A clear write carries data whose ones name the bits to drop. The bench drives pulses and writes at the falling edge and holds each for exactly one rising edge. It also always drives the address before it samples read data, so every raw transition an assertion examines comes from one known pulse or write. Enable and activity lines change only between register accesses, which keeps the combinational pending and status reads stable when sampled.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int NUM_CLASS = 4;
   localparam int MAP_ADDR_W = 12;
   localparam logic [MAP_ADDR_W-1:0] OFS_PEND_BASE = 12'h800;
   localparam logic [MAP_ADDR_W-1:0] OFS_RAW_BASE  = 12'h810;
   localparam logic [MAP_ADDR_W-1:0] OFS_ACTIVE    = 12'h820;
   localparam logic [MAP_ADDR_W-1:0] OFS_PRIO      = 12'h824;
   localparam logic [MAP_ADDR_W-1:0] OFS_ARB       = 12'h828;

   typedef enum logic [1:0] {
      CLS_DONE    = 2'd0,
      CLS_SRC_ERR = 2'd1,
      CLS_DST_ERR = 2'd2,
      CLS_CFG_ERR = 2'd3
   } evt_class_e;
endpackage

// File: rtl/evt_latch_bank.sv
module evt_latch_bank #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev_pulse,
   input  logic         clr_we,
   input  logic [N-1:0] clr_bits,
   input  logic [N-1:0] en,
   output logic [N-1:0] raw_q,
   output logic [N-1:0] pend
);
   logic [N-1:0] keep_mask;

   initial begin
      if (N < 1) $error("evt_latch_bank: N must be at least 1");
   end

   assign keep_mask = clr_we ? ~clr_bits : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & keep_mask) | ev_pulse;
   end

   assign pend = raw_q & en;

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_pulse) |=> ((raw_q & $past(ev_pulse)) == $past(ev_pulse))); // R2
   AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ev_pulse)) == '0)); // R2
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((raw_q & $past(clr_bits) & ~$past(ev_pulse)) == '0)); // R4
   AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && |(ev_pulse & clr_bits)) |=>
         ((raw_q & $past(ev_pulse & clr_bits)) == $past(ev_pulse & clr_bits))); // R5
endmodule

// File: rtl/irq_reg_read_mux.sv
module irq_reg_read_mux
   import dma_irq_pkg::*;
#(
   parameter int N      = 32,
   parameter int REG_W  = 32,
   parameter int ADDR_W = 12,
   parameter int ARB_W  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [N-1:0]      raw_w  [NUM_CLASS],
   input  logic [N-1:0]      pend_w [NUM_CLASS],
   input  logic [N-1:0]      active,
   input  logic [REG_W-1:0]  prio,
   input  logic [ARB_W-1:0]  arb,
   output logic [REG_W-1:0]  rdata
);
   function automatic logic [REG_W-1:0] widen_ch(input logic [N-1:0] v);
      logic [REG_W-1:0] t;
      t = '0;
      t[N-1:0] = v;
      return t;
   endfunction

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_CLASS; k++) begin
         if (addr == ADDR_W'(OFS_PEND_BASE + 12'(4 * k))) rdata = widen_ch(pend_w[k]);
         if (addr == ADDR_W'(OFS_RAW_BASE + 12'(4 * k)))  rdata = widen_ch(raw_w[k]);
      end
      if (addr == ADDR_W'(OFS_ACTIVE)) rdata = widen_ch(active);
      if (addr == ADDR_W'(OFS_PRIO))   rdata = prio;
      if (addr == ADDR_W'(OFS_ARB))    rdata[ARB_W-1:0] = arb;
   end

   AST_RESERVED_ZERO: assert property (@(addr)
      ((addr < ADDR_W'(OFS_PEND_BASE)) || (addr > ADDR_W'(OFS_ARB))) |-> (rdata == '0)); // R9
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int REG_W  = 32,
   parameter int ADDR_W = 12,
   parameter int ARB_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_done,
   input  logic [NUM_CH-1:0] evt_src_err,
   input  logic [NUM_CH-1:0] evt_dst_err,
   input  logic [NUM_CH-1:0] evt_cfg_err,
   input  logic [NUM_CH-1:0] ch_irq_en,
   input  logic [NUM_CH-1:0] ch_active,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [REG_W-1:0]  grp_prio,
   output logic [ARB_W-1:0]  arb_sel,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(OFS_PRIO);
   localparam logic [ADDR_W-1:0] A_ARB  = ADDR_W'(OFS_ARB);

   initial begin
      if (NUM_CH < 1 || NUM_CH > REG_W) $error("dma_irq_status: NUM_CH must be 1..REG_W");
      if (ADDR_W < MAP_ADDR_W)          $error("dma_irq_status: ADDR_W too small for map");
      if (ARB_W < 1 || ARB_W > REG_W)   $error("dma_irq_status: ARB_W out of range");
   end

   logic [NUM_CH-1:0] ev_by_cls   [NUM_CLASS];
   logic [NUM_CH-1:0] raw_by_cls  [NUM_CLASS];
   logic [NUM_CH-1:0] pend_by_cls [NUM_CLASS];
   logic [NUM_CLASS-1:0] cls_any;

   assign ev_by_cls[CLS_DONE]    = evt_done;
   assign ev_by_cls[CLS_SRC_ERR] = evt_src_err;
   assign ev_by_cls[CLS_DST_ERR] = evt_dst_err;
   assign ev_by_cls[CLS_CFG_ERR] = evt_cfg_err;

   for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
      logic clr_hit;
      assign clr_hit = reg_we && (reg_addr == ADDR_W'(OFS_RAW_BASE + 12'(4 * k)));
      evt_latch_bank #(.N(NUM_CH)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .ev_pulse (ev_by_cls[k]),
         .clr_we   (clr_hit),
         .clr_bits (reg_wdata[NUM_CH-1:0]),
         .en       (ch_irq_en),
         .raw_q    (raw_by_cls[k]),
         .pend     (pend_by_cls[k])
      );
      assign cls_any[k] = |pend_by_cls[k];
   end

   assign irq = |cls_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_prio <= '0;
         arb_sel  <= '0;
      end else if (reg_we) begin
         if (reg_addr == A_PRIO) grp_prio <= reg_wdata;
         if (reg_addr == A_ARB)  arb_sel  <= reg_wdata[ARB_W-1:0];
      end
   end

   irq_reg_read_mux #(.N(NUM_CH), .REG_W(REG_W), .ADDR_W(ADDR_W), .ARB_W(ARB_W)) u_rd (
      .addr   (reg_addr),
      .raw_w  (raw_by_cls),
      .pend_w (pend_by_cls),
      .active (ch_active),
      .prio   (grp_prio),
      .arb    (arb_sel),
      .rdata  (reg_rdata)
   );

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|ch_irq_en)); // R6
   AST_ARB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == A_ARB) |=> $stable(arb_sel)); // R8
   AST_PRIO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == A_PRIO) |=> $stable(grp_prio)); // R8
endmodule

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
   localparam int N = 32;
   logic clk = 0;
   logic rst_n = 0;
   logic [N-1:0] evt_done = '0, evt_src_err = '0, evt_dst_err = '0, evt_cfg_err = '0;
   logic [N-1:0] ch_irq_en = '0, ch_active = '0;
   logic [11:0] reg_addr = '0;
   logic reg_we = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, grp_prio;
   logic [1:0] arb_sel;
   logic irq;

   int n_chk = 0, n_err = 0;

   typedef struct { logic [31:0] exp; logic [11:0] addr; string tag; } rd_item_t;
   rd_item_t exp_q[$];
   event chk_ev;

   always #5 clk = ~clk;

   dma_irq_status dut (
      .clk(clk), .rst_n(rst_n), .evt_done(evt_done), .evt_src_err(evt_src_err),
      .evt_dst_err(evt_dst_err), .evt_cfg_err(evt_cfg_err), .ch_irq_en(ch_irq_en),
      .ch_active(ch_active), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .grp_prio(grp_prio), .arb_sel(arb_sel), .irq(irq)
   );

   // monitor: pops expected read values and compares against the port
   initial forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
         rd_item_t it;
         it = exp_q.pop_front();
         n_chk++;
         if (reg_rdata !== it.exp) begin
            n_err++;
            $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, reg_rdata, it.exp);
         end
      end
   end

   // driver: read request with expected value pushed to the scoreboard
   task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      exp_q.push_back('{exp: e, addr: a, tag: tag});
      ->chk_ev;
      #1;
   endtask

   task automatic check_val(input logic [31:0] act, input logic [31:0] e, input string tag);
      n_chk++;
      if (act !== e) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, e);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1;
      @(negedge clk);
      reg_we = 0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [N-1:0] d, input logic [N-1:0] s,
                        input logic [N-1:0] t, input logic [N-1:0] c);
      @(negedge clk);
      evt_done = d; evt_src_err = s; evt_dst_err = t; evt_cfg_err = c;
      @(negedge clk);
      evt_done = '0; evt_src_err = '0; evt_dst_err = '0; evt_cfg_err = '0;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check_val({31'd0, irq}, 0, "R1 irq after reset");
      for (int k = 0; k < 4; k++) expect_rd(12'h810 + 12'(4*k), 0, "R1 raw zero");
      expect_rd(12'h824, 0, "R1 prio zero");
      expect_rd(12'h828, 0, "R1 arb zero");

      // R2 events in every class on distinct channels
      ch_irq_en = '1;
      pulse(32'h0000_0008, 32'h0000_0001, 32'h8000_0000, 32'h0000_0080);
      repeat (2) @(negedge clk);
      expect_rd(12'h810, 32'h0000_0008, "R2 done raw");
      expect_rd(12'h814, 32'h0000_0001, "R2 src raw");
      expect_rd(12'h818, 32'h8000_0000, "R2 dst raw");
      expect_rd(12'h81C, 32'h0000_0080, "R2 cfg raw");
      check_val({31'd0, irq}, 1, "R6 irq with pending");

      // R3 enable masking
      ch_irq_en = 32'h0000_00FF;
      expect_rd(12'h800, 32'h0000_0008, "R3 done pend");
      expect_rd(12'h808, 32'h0000_0000, "R3 dst pend masked");
      expect_rd(12'h818, 32'h8000_0000, "R3 dst raw unmasked");
      ch_irq_en = '0;
      #1;
      check_val({31'd0, irq}, 0, "R6 irq all masked");
      ch_irq_en = '1;

      // R9 pending writes ignored
      wr(12'h800, 32'hFFFF_FFFF);
      expect_rd(12'h810, 32'h0000_0008, "R9 pending write ignored");

      // R4 clear selected bits only
      pulse(32'h0000_0030, '0, '0, '0);
      wr(12'h810, 32'h0000_0018);
      expect_rd(12'h810, 32'h0000_0020, "R4 partial clear");
      expect_rd(12'h814, 32'h0000_0001, "R4 other class untouched");

      // R5 event beats clear in same cycle
      @(negedge clk);
      evt_cfg_err = 32'h0000_0080; reg_addr = 12'h81C; reg_wdata = 32'h0000_0081; reg_we = 1;
      @(negedge clk);
      evt_cfg_err = '0; reg_we = 0;
      expect_rd(12'h81C, 32'h0000_0080, "R5 event wins over clear");

      // R7 live activity, writes ignored
      ch_active = 32'hA5A5_0F0F;
      expect_rd(12'h820, 32'hA5A5_0F0F, "R7 active word");
      wr(12'h820, 32'h0);
      expect_rd(12'h820, 32'hA5A5_0F0F, "R7 active write ignored");

      // R8 prio and arbitration
      wr(12'h824, 32'hDEAD_BEEF);
      wr(12'h828, 32'hFFFF_FFFF);
      expect_rd(12'h824, 32'hDEAD_BEEF, "R8 prio read");
      expect_rd(12'h828, 32'h0000_0003, "R8 arb masked");
      check_val(grp_prio, 32'hDEAD_BEEF, "R8 prio port");
      check_val({30'd0, arb_sel}, 3, "R8 arb port");
      wr(12'h828, 32'h0);
      check_val({30'd0, arb_sel}, 0, "R8 arb equal priority");

      // R9 reserved addresses
      wr(12'h82C, 32'hFFFF_FFFF);
      wr(12'h7FC, 32'hFFFF_FFFF);
      expect_rd(12'h82C, 0, "R9 reserved high zero");
      expect_rd(12'h7FC, 0, "R9 reserved low zero");
      expect_rd(12'h824, 32'hDEAD_BEEF, "R9 reserved write no effect");
      expect_rd(12'h81C, 32'h0000_0080, "R9 raw untouched by reserved");

      // R10 clear-all
      for (int k = 0; k < 4; k++) wr(12'h810 + 12'(4*k), 32'hFFFF_FFFF);
      for (int k = 0; k < 4; k++) expect_rd(12'h800 + 12'(4*k), 0, "R10 pending cleared");
      check_val({31'd0, irq}, 0, "R10 irq low");

      // R2 bit stays set across idle cycles
      pulse('0, 32'h0001_0000, '0, '0);
      repeat (5) @(negedge clk);
      expect_rd(12'h814, 32'h0001_0000, "R2 sticky");
      check_val({31'd0, irq}, 1, "R6 irq from src class");

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule